// File: doc/BRIEF.md
# CPU Exception Entry Sequencer

This block steers a 32-bit processor core into exception handling. It watches the external reset pin together with the non-maskable interrupt level, and takes in request flags from the decoder, the interrupt priority controller and the address checker. Once it accepts a request, it runs a fixed series of 32-bit accesses on a plain memory port. For a reset it reads the start PC and stack pointer from the vector table. For any other exception it saves the status word and the return PC on the stack, then reads the handler address.

When the series finishes, the block holds a single-cycle load strobe. With it the core takes the new PC and stack pointer, and where it applies, a vector-base clear and a new interrupt mask. The block never reads the register file on its own. The core supplies the current status word, return PC, stack pointer and vector base as inputs, and they are captured at the moment of acceptance.

Top module: `exc_entry_seq`

## Requirements
- R1: A rising edge on `rst_pin` with `nmi_lvl` high starts a power-on reset: two reads, the first from address 0x00000000 (its data becomes `ld_pc`), the second from 0x00000004 (its data becomes `ld_sp`).
- R2: A rising edge on `rst_pin` with `nmi_lvl` low starts a manual reset: reads from 0x00000008 (new PC) then 0x0000000C (new SP).
- R3: At the end of either reset, the load strobe comes with `ld_vbr_clr`=1, `ld_imask_en`=1 and `ld_imask`=4'b1111.
- R4: For a non-reset exception, the block first writes the captured `cur_sr` to `cur_r15`-4, then writes the captured `cur_pc` to `cur_r15`-8. `ld_sp` becomes `cur_r15`-8.
- R5: After the two writes, the block reads the word at `cur_vbr` + 4 × vector number, and that word becomes `ld_pc`. The vector numbers are 9 for an address error, 4 for an illegal opcode and 6 for an illegal slot instruction. A trap uses `trap_imm` and an interrupt uses `irq_vec`.
- R6: For an interrupt entry, `ld_imask_en`=1 and `ld_imask`=`irq_level`. Every other non-reset entry gives `ld_imask_en`=0, `ld_imask`=0 and `ld_vbr_clr`=0.
- R7: `aerr_req` and `irq_req` are taken only in a cycle with `inst_done`=1. Decoder flags (`insn_valid` with its qualifiers) and `trap_exec` are taken regardless of `inst_done`.
- R8: With `insn_valid`=1, the following cases apply. In a delay slot (`insn_in_slot`=1), either `insn_undef` or `insn_pc_mod` raises the slot exception (vector 6). Outside a slot, `insn_undef` raises the illegal exception (vector 4). `insn_pc_mod` outside a slot raises nothing.
- R9: When several requests come in the same cycle, the order is address error, then interrupt, then slot exception, then illegal opcode, then trap.
- R10: `busy` rises in the cycle after acceptance and stays high until the cycle after the one-cycle `ld_valid` strobe. Requests that come while `busy` is high are dropped.
- R11: A memory request holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until the cycle in which `mem_ack` is high.
- R12: `rst_pin` low ends any sequence under way. There is no memory request and no load strobe while the pin is low, and the next rising edge starts a fresh reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rst_pin | input | 1 | External reset pin level, synchronous |
| nmi_lvl | input | 1 | NMI pin level, selects reset kind |
| inst_done | input | 1 | Current instruction completes this cycle |
| aerr_req | input | 1 | Address error pending |
| irq_req | input | 1 | Interrupt accepted by priority controller |
| irq_level | input | 4 | Priority level of that interrupt |
| irq_vec | input | 8 | Vector number of that interrupt |
| insn_valid | input | 1 | Decoder flags valid this cycle |
| insn_undef | input | 1 | Decoded opcode is undefined |
| insn_in_slot | input | 1 | Decoded opcode sits in a delay slot |
| insn_pc_mod | input | 1 | Decoded opcode rewrites the PC |
| trap_exec | input | 1 | Trap instruction executing |
| trap_imm | input | 8 | Trap vector number |
| cur_sr | input | 32 | Status word to save |
| cur_pc | input | 32 | Return PC to save |
| cur_r15 | input | 32 | Current stack pointer |
| cur_vbr | input | 32 | Current vector base |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with ack |
| mem_ack | input | 1 | Access completes this cycle |
| busy | output | 1 | Sequence in progress |
| ld_valid | output | 1 | One-cycle load strobe for the core |
| ld_pc | output | 32 | New PC |
| ld_sp | output | 32 | New R15 |
| ld_vbr_clr | output | 1 | Clear the vector base |
| ld_imask_en | output | 1 | Load a new interrupt mask |
| ld_imask | output | 4 | New interrupt mask |

## Verification
A wrong state register shows up at once on the memory port. If the state skips a step, sits at the wrong address or resumes after an abort, the next request is an access the scoreboard did not expect. It is caught in the cycle it is acknowledged. Capture errors, such as a stale stack pointer, a wrong vector base or a wrong source priority, show up as a wrong address or write data within the first three accesses. A bad mask or reset-kind flag is held back until the load strobe, where the compared fields expose it a cycle after the last acknowledgement.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN   = 32;
  localparam int WBYTES = XLEN / 8;
  localparam int WSHIFT = $clog2(WBYTES);

  // grant bit positions; lower index wins
  localparam int G_AERR = 0;
  localparam int G_IRQ  = 1;
  localparam int G_SLOT = 2;
  localparam int G_ILL  = 3;
  localparam int G_TRAP = 4;
  localparam int NGRANT = 5;

  typedef enum logic [2:0] {
    S_IDLE, S_RST_PC, S_RST_SP, S_PUSH_SR, S_PUSH_PC, S_VEC, S_DONE
  } seq_state_e;

  // handler address slot inside the table
  function automatic logic [XLEN-1:0] vec_slot_addr(input logic [XLEN-1:0] base,
                                                    input logic [XLEN-1:0] num);
    return base + (num << WSHIFT);
  endfunction

  // idx-th word below the stack top (downward growth)
  function automatic logic [XLEN-1:0] stack_slot(input logic [XLEN-1:0] sp, input int idx);
    return sp - XLEN'(idx * WBYTES);
  endfunction

  // first word of the reset pair
  function automatic logic [XLEN-1:0] reset_base(input logic poweron);
    return poweron ? '0 : XLEN'(2 * WBYTES);
  endfunction

  // keep lowest set bit
  function automatic logic [NGRANT-1:0] pick_first(input logic [NGRANT-1:0] r);
    return r & (~r + NGRANT'(1));
  endfunction
endpackage

// File: rtl/exc_rst_detect.sv
module exc_rst_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_pin,
  input  logic nmi_lvl,
  output logic rst_edge,
  output logic rst_poweron
);
  logic pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= rst_pin;
  end

  assign rst_edge    = rst_pin & ~pin_q;
  assign rst_poweron = nmi_lvl;

  // an edge is a single-cycle event
  p_edge_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_edge |=> !rst_edge);
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter import exc_pkg::*; #(
  parameter int VNW      = 8,
  parameter int MW       = 4,
  parameter int VEC_ILL  = 4,
  parameter int VEC_SLOT = 6,
  parameter int VEC_AERR = 9
) (
  input  logic              inst_done,
  input  logic              aerr_req,
  input  logic              irq_req,
  input  logic [MW-1:0]     irq_level,
  input  logic [VNW-1:0]    irq_vec,
  input  logic              insn_valid,
  input  logic              insn_undef,
  input  logic              insn_in_slot,
  input  logic              insn_pc_mod,
  input  logic              trap_exec,
  input  logic [VNW-1:0]    trap_imm,
  output logic [NGRANT-1:0] grant_oh,
  output logic [VNW-1:0]    grant_vec,
  output logic [MW-1:0]     grant_level
);
  logic [NGRANT-1:0] raw;

  always_comb begin
    raw         = '0;
    raw[G_AERR] = aerr_req & inst_done;
    raw[G_IRQ]  = irq_req & inst_done;
    raw[G_SLOT] = insn_valid & insn_in_slot & (insn_undef | insn_pc_mod);
    raw[G_ILL]  = insn_valid & ~insn_in_slot & insn_undef;
    raw[G_TRAP] = trap_exec;
  end

  assign grant_oh = pick_first(raw);

  always_comb begin
    grant_vec   = '0;
    grant_level = '0;
    if (grant_oh[G_AERR])      grant_vec = VNW'(VEC_AERR);
    else if (grant_oh[G_IRQ]) begin
      grant_vec   = irq_vec;
      grant_level = irq_level;
    end
    else if (grant_oh[G_SLOT]) grant_vec = VNW'(VEC_SLOT);
    else if (grant_oh[G_ILL])  grant_vec = VNW'(VEC_ILL);
    else if (grant_oh[G_TRAP]) grant_vec = trap_imm;
  end
endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm import exc_pkg::*; #(
  parameter int VNW = 8,
  parameter int MW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rst_pin,
  input  logic            rst_edge,
  input  logic            rst_poweron,
  input  logic            accept,
  input  logic [VNW-1:0]  grant_vec,
  input  logic [MW-1:0]   grant_level,
  input  logic            grant_irq,
  input  logic [XLEN-1:0] cur_sr,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] cur_r15,
  input  logic [XLEN-1:0] cur_vbr,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic            mem_ack,
  output logic            busy,
  output logic            ld_valid,
  output logic [XLEN-1:0] ld_pc,
  output logic [XLEN-1:0] ld_sp,
  output logic            ld_vbr_clr,
  output logic            ld_imask_en,
  output logic [MW-1:0]   ld_imask
);
  seq_state_e      state;
  logic [XLEN-1:0] sp_q, sr_q, pc_q, vaddr_q, rbase_q;
  logic            irq_q;
  logic [MW-1:0]   lvl_q;
  logic            step_done;

  assign busy      = (state != S_IDLE);
  assign ld_valid  = (state == S_DONE) & rst_pin;
  assign step_done = mem_req & mem_ack;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      S_RST_PC:  begin mem_req = rst_pin; mem_addr = rbase_q; end
      S_RST_SP:  begin mem_req = rst_pin; mem_addr = rbase_q + XLEN'(WBYTES); end
      S_PUSH_SR: begin
        mem_req = rst_pin; mem_we = 1'b1;
        mem_addr = stack_slot(sp_q, 1); mem_wdata = sr_q;
      end
      S_PUSH_PC: begin
        mem_req = rst_pin; mem_we = 1'b1;
        mem_addr = stack_slot(sp_q, 2); mem_wdata = pc_q;
      end
      S_VEC:     begin mem_req = rst_pin; mem_addr = vaddr_q; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      sp_q        <= '0;
      sr_q        <= '0;
      pc_q        <= '0;
      vaddr_q     <= '0;
      rbase_q     <= '0;
      irq_q       <= 1'b0;
      lvl_q       <= '0;
      ld_pc       <= '0;
      ld_sp       <= '0;
      ld_vbr_clr  <= 1'b0;
      ld_imask_en <= 1'b0;
      ld_imask    <= '0;
    end else if (!rst_pin) begin
      state <= S_IDLE;
    end else if (rst_edge) begin
      rbase_q <= reset_base(rst_poweron);
      state   <= S_RST_PC;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          sp_q    <= cur_r15;
          sr_q    <= cur_sr;
          pc_q    <= cur_pc;
          vaddr_q <= vec_slot_addr(cur_vbr, XLEN'(grant_vec));
          irq_q   <= grant_irq;
          lvl_q   <= grant_level;
          state   <= S_PUSH_SR;
        end
        S_RST_PC: if (step_done) begin
          ld_pc <= mem_rdata;
          state <= S_RST_SP;
        end
        S_RST_SP: if (step_done) begin
          ld_sp       <= mem_rdata;
          ld_vbr_clr  <= 1'b1;
          ld_imask_en <= 1'b1;
          ld_imask    <= '1;
          state       <= S_DONE;
        end
        S_PUSH_SR: if (step_done) state <= S_PUSH_PC;
        S_PUSH_PC: if (step_done) state <= S_VEC;
        S_VEC: if (step_done) begin
          ld_pc       <= mem_rdata;
          ld_sp       <= stack_slot(sp_q, 2);
          ld_vbr_clr  <= 1'b0;
          ld_imask_en <= irq_q;
          ld_imask    <= irq_q ? lvl_q : '0;
          state       <= S_DONE;
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11: request stays put until acknowledged
  p_hold_req_r11: assert property (@(posedge clk) disable iff (!rst_n || !rst_pin)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R12: pin low silences the memory port
  p_quiet_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_pin |=> !mem_req);

  // R3: reset completion loads a full mask
  p_reset_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_vbr_clr) |-> (ld_imask_en && ld_imask == '1));

  // R10: load strobe is one cycle and only while busy
  p_ld_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> !ld_valid);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq import exc_pkg::*; #(
  parameter int VNW      = 8,
  parameter int MW       = 4,
  parameter int VEC_ILL  = 4,
  parameter int VEC_SLOT = 6,
  parameter int VEC_AERR = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rst_pin,
  input  logic            nmi_lvl,
  input  logic            inst_done,
  input  logic            aerr_req,
  input  logic            irq_req,
  input  logic [MW-1:0]   irq_level,
  input  logic [VNW-1:0]  irq_vec,
  input  logic            insn_valid,
  input  logic            insn_undef,
  input  logic            insn_in_slot,
  input  logic            insn_pc_mod,
  input  logic            trap_exec,
  input  logic [VNW-1:0]  trap_imm,
  input  logic [XLEN-1:0] cur_sr,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] cur_r15,
  input  logic [XLEN-1:0] cur_vbr,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic            mem_ack,
  output logic            busy,
  output logic            ld_valid,
  output logic [XLEN-1:0] ld_pc,
  output logic [XLEN-1:0] ld_sp,
  output logic            ld_vbr_clr,
  output logic            ld_imask_en,
  output logic [MW-1:0]   ld_imask
);
  logic              rst_edge, rst_poweron;
  logic [NGRANT-1:0] grant_oh;
  logic [VNW-1:0]    grant_vec;
  logic [MW-1:0]     grant_level;
  logic              accept;

  exc_rst_detect u_rst (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .nmi_lvl(nmi_lvl),
    .rst_edge(rst_edge), .rst_poweron(rst_poweron)
  );

  exc_arbiter #(.VNW(VNW), .MW(MW), .VEC_ILL(VEC_ILL), .VEC_SLOT(VEC_SLOT),
                .VEC_AERR(VEC_AERR)) u_arb (
    .inst_done(inst_done), .aerr_req(aerr_req), .irq_req(irq_req),
    .irq_level(irq_level), .irq_vec(irq_vec), .insn_valid(insn_valid),
    .insn_undef(insn_undef), .insn_in_slot(insn_in_slot),
    .insn_pc_mod(insn_pc_mod), .trap_exec(trap_exec), .trap_imm(trap_imm),
    .grant_oh(grant_oh), .grant_vec(grant_vec), .grant_level(grant_level)
  );

  // reset edge outranks everything; busy drops new requests
  assign accept = (|grant_oh) & ~busy & rst_pin & ~rst_edge;

  exc_seq_fsm #(.VNW(VNW), .MW(MW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .rst_edge(rst_edge),
    .rst_poweron(rst_poweron), .accept(accept), .grant_vec(grant_vec),
    .grant_level(grant_level), .grant_irq(grant_oh[G_IRQ]),
    .cur_sr(cur_sr), .cur_pc(cur_pc), .cur_r15(cur_r15), .cur_vbr(cur_vbr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .busy(busy), .ld_valid(ld_valid), .ld_pc(ld_pc), .ld_sp(ld_sp),
    .ld_vbr_clr(ld_vbr_clr), .ld_imask_en(ld_imask_en), .ld_imask(ld_imask)
  );

  // R9: at most one source granted
  p_single_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_oh));

  // R7: completion-gated sources need inst_done
  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_oh[G_AERR] || grant_oh[G_IRQ]) |-> inst_done);

  // R10: acceptance makes the block busy next cycle
  p_busy_follows_r10: assert property (@(posedge clk) disable iff (!rst_n || !rst_pin)
    accept |=> busy);
endmodule

// File: tb/tb_exc_entry_seq.sv
`timescale 1ns/1ps
module tb_exc_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n, rst_pin, nmi_lvl, inst_done, aerr_req, irq_req;
  logic [3:0]  irq_level;
  logic [7:0]  irq_vec, trap_imm;
  logic        insn_valid, insn_undef, insn_in_slot, insn_pc_mod, trap_exec;
  logic [31:0] cur_sr, cur_pc, cur_r15, cur_vbr;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        busy, ld_valid, ld_vbr_clr, ld_imask_en;
  logic [31:0] ld_pc, ld_sp;
  logic [3:0]  ld_imask;

  int n_chk = 0, n_fail = 0, cyc = 0, lat_cfg = 0, lat_cnt = 0;
  logic [64:0] exp_mem[$];   // {we, addr, data}
  logic [69:0] exp_ld[$];    // {pc, sp, vbr_clr, imask_en, imask}

  always #4 clk = ~clk;

  exc_entry_seq dut (.*);

  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9bdf;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [69:0] act, input logic [69:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // driver side of the scoreboard
  task automatic exp_reset(input logic poweron);
    logic [31:0] b = poweron ? 32'h0 : 32'h8;
    exp_mem.push_back({1'b0, b, 32'h0});
    exp_mem.push_back({1'b0, b + 32'd4, 32'h0});
    exp_ld.push_back({mem_fn(b), mem_fn(b + 32'd4), 1'b1, 1'b1, 4'hf});
  endtask

  task automatic exp_exc(input logic [7:0] vec, input logic irq, input logic [3:0] lvl);
    logic [31:0] va = cur_vbr + {22'h0, vec, 2'b00};
    exp_mem.push_back({1'b1, cur_r15 - 32'd4, cur_sr});
    exp_mem.push_back({1'b1, cur_r15 - 32'd8, cur_pc});
    exp_mem.push_back({1'b0, va, 32'h0});
    exp_ld.push_back({mem_fn(va), cur_r15 - 32'd8, 1'b0, irq, irq ? lvl : 4'h0});
  endtask

  // memory model and monitor
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (lat_cnt >= lat_cfg) begin
        logic [64:0] got, e;
        mem_ack   = 1'b1;
        mem_rdata = mem_fn(mem_addr);
        lat_cnt   = 0;
        got = {mem_we, mem_addr, mem_we ? mem_wdata : 32'h0};
        if (exp_mem.size() == 0) chk(1'b0, "R10 R12 unexpected memory op", {5'h0, got}, 70'h0);
        else begin
          e = exp_mem.pop_front();
          chk(got == e, "R1 R2 R4 R5 R9 memory op", {5'h0, got}, {5'h0, e});
        end
      end else lat_cnt++;
    end else lat_cnt = 0;
  end

  always @(negedge clk) begin
    if (rst_n && ld_valid) begin
      logic [69:0] got, e;
      got = {ld_pc, ld_sp, ld_vbr_clr, ld_imask_en, ld_imask};
      if (exp_ld.size() == 0) chk(1'b0, "R10 unexpected load strobe", got, 70'h0);
      else begin
        e = exp_ld.pop_front();
        chk(got == e, "R3 R5 R6 load values", got, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      summary();
    end
  end

  task automatic wait_idle(input string tag);
    int k = 0;
    @(negedge clk);
    while ((busy || exp_mem.size() != 0 || exp_ld.size() != 0) && k < 200) begin
      @(negedge clk); k++;
    end
    chk(!busy && exp_mem.size() == 0 && exp_ld.size() == 0, tag,
        {busy, 37'h0, exp_mem.size()}, 70'h0);
  endtask

  task automatic clear_reqs();
    aerr_req = 0; irq_req = 0; insn_valid = 0; insn_undef = 0;
    insn_in_slot = 0; insn_pc_mod = 0; trap_exec = 0; inst_done = 0;
  endtask

  task automatic expect_quiet(input string tag);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!busy && !mem_req, tag, {busy, mem_req}, 70'h0);
    end
  endtask

  initial begin
    rst_n = 0; rst_pin = 0; nmi_lvl = 0; mem_ack = 0; mem_rdata = 0;
    irq_level = 0; irq_vec = 0; trap_imm = 0;
    clear_reqs();
    cur_sr = 32'h0000_00f0; cur_pc = 32'h0000_2468;
    cur_r15 = 32'h0000_1000; cur_vbr = 32'h0000_4000;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !ld_valid, "R10 reset state", {busy, mem_req, ld_valid}, 70'h0);
    rst_n = 1;
    @(negedge clk);

    // R1 R3: power-on reset
    nmi_lvl = 1; exp_reset(1'b1); rst_pin = 1;
    wait_idle("R1 power-on sequence complete");

    // R2: manual reset with one wait state
    lat_cfg = 1;
    rst_pin = 0; @(negedge clk);
    nmi_lvl = 0; exp_reset(1'b0); rst_pin = 1;
    wait_idle("R2 manual sequence complete");

    // R8 R4 R5: illegal opcode outside slot
    exp_exc(8'd4, 0, 0);
    insn_valid = 1; insn_undef = 1; @(negedge clk); clear_reqs();
    wait_idle("R8 illegal sequence");

    // R8: undefined opcode in slot
    cur_r15 = 32'h0000_0ff8; cur_sr = 32'h0000_0031;
    exp_exc(8'd6, 0, 0);
    insn_valid = 1; insn_undef = 1; insn_in_slot = 1; @(negedge clk); clear_reqs();
    wait_idle("R8 slot undefined sequence");

    // R8: PC-modifying opcode in slot, two wait states
    lat_cfg = 2;
    exp_exc(8'd6, 0, 0);
    insn_valid = 1; insn_pc_mod = 1; insn_in_slot = 1; @(negedge clk); clear_reqs();
    wait_idle("R8 slot branch sequence");

    // R8: PC-modifying opcode outside slot is fine
    lat_cfg = 0;
    insn_valid = 1; insn_pc_mod = 1; @(negedge clk); clear_reqs();
    expect_quiet("R8 branch outside slot no entry");

    // R8 R5: trap
    cur_vbr = 32'h0001_0000;
    exp_exc(8'h21, 0, 0);
    trap_imm = 8'h21; trap_exec = 1; @(negedge clk); clear_reqs();
    wait_idle("R8 trap sequence");

    // R7: interrupt and address error wait for inst_done
    irq_req = 1; aerr_req = 1; irq_level = 4'd5; irq_vec = 8'h40; inst_done = 0;
    @(negedge clk); clear_reqs();
    expect_quiet("R7 no entry without inst_done");

    // R6: interrupt entry
    exp_exc(8'h40, 1, 4'd5);
    irq_req = 1; inst_done = 1; @(negedge clk); clear_reqs();
    wait_idle("R6 interrupt sequence");

    // R9: address error beats all others
    exp_exc(8'd9, 0, 0);
    aerr_req = 1; irq_req = 1; inst_done = 1; insn_valid = 1; insn_undef = 1; trap_exec = 1;
    @(negedge clk); clear_reqs();
    wait_idle("R9 address error first");

    // R9: interrupt beats instruction exceptions
    irq_level = 4'd9; irq_vec = 8'h55;
    exp_exc(8'h55, 1, 4'd9);
    irq_req = 1; inst_done = 1; insn_valid = 1; insn_undef = 1;
    @(negedge clk); clear_reqs();
    wait_idle("R9 interrupt over illegal");

    // R9: slot beats trap
    exp_exc(8'd6, 0, 0);
    insn_valid = 1; insn_undef = 1; insn_in_slot = 1; trap_exec = 1;
    @(negedge clk); clear_reqs();
    wait_idle("R9 slot over trap");

    // R10: requests while busy are dropped
    lat_cfg = 1;
    exp_exc(8'd4, 0, 0);
    insn_valid = 1; insn_undef = 1; @(negedge clk); clear_reqs();
    chk(busy, "R10 busy after accept", {69'h0, busy}, 70'h1);
    irq_req = 1; inst_done = 1; trap_exec = 1; @(negedge clk); clear_reqs();
    wait_idle("R10 busy sequence");
    expect_quiet("R10 dropped request stays dropped");

    // R11: request held during wait states
    lat_cfg = 3;
    exp_exc(8'h12, 0, 0);
    trap_imm = 8'h12; trap_exec = 1; @(negedge clk); clear_reqs();
    chk(mem_req && mem_we && mem_addr == cur_r15 - 32'd4, "R11 request presented",
        {mem_req, mem_we, mem_addr}, {2'b11, cur_r15 - 32'd4});
    @(negedge clk);
    chk(mem_req && mem_addr == cur_r15 - 32'd4 && mem_wdata == cur_sr, "R11 request held",
        {mem_req, mem_addr, mem_wdata}, {1'b1, cur_r15 - 32'd4, cur_sr});
    wait_idle("R11 sequence complete");

    // R12: pin low aborts a reset sequence
    lat_cfg = 6;
    rst_pin = 0; @(negedge clk);
    nmi_lvl = 1; rst_pin = 1;
    repeat (2) @(negedge clk);
    chk(mem_req && busy, "R12 reset sequence running", {mem_req, busy}, 70'h3);
    rst_pin = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!mem_req && !ld_valid && !busy, "R12 silent while pin low",
          {mem_req, ld_valid, busy}, 70'h0);
    end
    lat_cfg = 0; nmi_lvl = 0; exp_reset(1'b0); rst_pin = 1;
    wait_idle("R12 fresh reset after abort");

    repeat (3) @(negedge clk);
    summary();
  end
endmodule